// File: doc/BRIEF.md
# Bit-Serial Neuron Weighted-Sum Array

This block forms the weighted input sums of a layer of neurons. A bank of lanes, one per output neuron (16 by default), works side by side. For each input neuron it latches one row of the internal weight memory, then walks the bits of that input's state from the most significant bit down. It uses shift-and-add steps, so it needs no full multiplier. Once every input has been applied, the sums leave the block one bit at a time on a valid/ready stream, towards an activation function outside the block. The activated values come back on a second valid/ready stream and are written into the neural state registers, ready for the next pass.

Each neural state has a working register and a shadow register. In asynchronous mode a returned value goes straight into the working register. In synchronous mode returned values wait in the shadow registers, and all of them move into the working registers together once every state has been returned. A parallel partial-sum input can seed each accumulator, so that several arrays can be chained to build wider or more precise networks.

Stream rules: on the output stream, `so_valid` stays high and `so_data`/`so_last` hold their value until a cycle with `so_ready` high. A bit transfers on a clock edge where both are high. On the return stream, a value transfers on an edge where `wb_valid` and `wb_ready` are both high. `wb_ready` is high only while the array is idle.

Top module: `nm_mac_array`

## Requirements
- R1: A `start` accepted while idle makes every lane k compute the sum over inputs j of w[j][k]·y[j], using two's-complement arithmetic, modulo 2^ACC_W (32). The sums are sent lane 0 first, and each sum is sent LSB first.
- R2: When `psum_en` is high at the start cycle, lane k adds the signed value `psum_in[k*32 +: 32]` to its sum. When `psum_en` is low, the accumulator starts from zero.
- R3: With `wide_w`=1 a weight is the full signed 16-bit word. With `wide_w`=0 a weight is bits 7:0 sign-extended, and bits 15:8 have no effect.
- R4: The state width is `state_msb`+1 (1 to 8 bits). Bits of a state above `state_msb` have no effect. Bit `state_msb` counts as −2^`state_msb`.
- R5: `busy` is high from the cycle after an accepted start. The first `so_valid` appears exactly 16·(`state_msb`+1) clock edges after the start edge.
- R6: Exactly 16×32 bits are transferred per pass. `so_last` marks bit 31 of each sum. While `so_valid` is high and `so_ready` is low, `so_data` and `so_last` hold their value.
- R7: `wb_ready` is low while `busy` is high. A returned value carries an 8-bit state in `wb_data`, and `wb_idx` selects the input neuron it belongs to.
- R8: With `sync_mode`=0, an accepted return value replaces the working state at once, and the next pass uses it.
- R9: With `sync_mode`=1, returned values do not change the working states until all 16 indices have been returned since the last copy. At that point all 16 shadow values become the working states in one step.
- R10: A `start` raised while `busy` is high is ignored. No second pass follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| busy | output | 1 | Pass in progress |
| wide_w | input | 1 | 1: 16-bit weights, 0: 8-bit weights (sampled at start) |
| state_msb | input | 3 | State width minus one (sampled at start) |
| psum_en | input | 1 | Seed accumulators from psum_in (sampled at start) |
| psum_in | input | 512 | Per-lane partial sums, lane k at bits k*32 +: 32 |
| sync_mode | input | 1 | 1: shadowed state update, 0: direct update |
| w_we | input | 1 | Weight write enable |
| w_in_sel | input | 4 | Input neuron index j of the weight written |
| w_out_sel | input | 4 | Lane index k of the weight written |
| w_data | input | 16 | Weight value written |
| wb_valid | input | 1 | Returned state valid |
| wb_ready | output | 1 | Returned state accepted (idle only) |
| wb_idx | input | 4 | Input neuron index of the returned state |
| wb_data | input | 8 | Returned state value |
| so_valid | output | 1 | Serial sum bit valid |
| so_ready | input | 1 | Downstream takes the serial bit |
| so_data | output | 1 | Serial sum bit |
| so_last | output | 1 | Bit 31 of the current sum |

## Verification
Assertions check these properties on every cycle:
- The serial bit is held while it is back-pressured.
- The accumulators do not move outside a pass.
- The latched weight row stays steady between row loads.
- The multiply phase lasts exactly sixteen times the state width.
- No pass restarts once results are streaming.
- Direct write-back lands in the working register.
- A shadowed write that does not complete the set leaves the working states alone.

The arithmetic itself can only be shown by the bench scenarios. These cover the sums under both weight widths, every state width and partial-sum seeding, and the signed extremes. The bench scenarios also show which register set a later pass actually reads, and that a start pulse during streaming produces no extra output.

// File: rtl/nm_pkg.sv
package nm_pkg;
  localparam int DEF_LANES  = 16;
  localparam int DEF_INPUTS = 16;
  localparam int DEF_W_MAX  = 16;
  localparam int DEF_S_MAX  = 8;
  localparam int DEF_ACC_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_OUT  = 2'd2
  } nm_state_e;
endpackage

// File: rtl/nm_wstore.sv
module nm_wstore #(
  parameter int NUM_IN  = nm_pkg::DEF_INPUTS,
  parameter int NUM_OUT = nm_pkg::DEF_LANES,
  parameter int W_MAX   = nm_pkg::DEF_W_MAX,
  localparam int IN_AW  = $clog2(NUM_IN),
  localparam int OUT_AW = $clog2(NUM_OUT),
  localparam int W_NAR  = W_MAX / 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [IN_AW-1:0]                we_row,
  input  logic [OUT_AW-1:0]               we_col,
  input  logic [W_MAX-1:0]                we_data,
  input  logic                            row_load,
  input  logic [IN_AW-1:0]                row_sel,
  input  logic                            wide,
  output logic [NUM_OUT-1:0][W_MAX-1:0]   wt_eff
);
  logic [NUM_OUT-1:0][W_MAX-1:0] mem [NUM_IN];
  logic [NUM_OUT-1:0][W_MAX-1:0] lat;

  always_ff @(posedge clk) begin
    if (we) mem[we_row][we_col] <= we_data;
  end

  // Row latch: frees the memory while a product is being formed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat <= '0;
    else if (row_load) lat <= mem[row_sel];
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_ext
    assign wt_eff[k] = wide ? lat[k]
                            : {{(W_MAX-W_NAR){lat[k][W_NAR-1]}}, lat[k][W_NAR-1:0]};
  end

  // R1
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !row_load |=> $stable(lat));
endmodule

// File: rtl/nm_sbank.sv
module nm_sbank #(
  parameter int NUM_IN = nm_pkg::DEF_INPUTS,
  parameter int S_MAX  = nm_pkg::DEF_S_MAX,
  localparam int IN_AW = $clog2(NUM_IN)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IN_AW-1:0]              wr_idx,
  input  logic [S_MAX-1:0]              wr_data,
  input  logic                          sync_mode,
  output logic [NUM_IN-1:0][S_MAX-1:0]  work
);
  logic [NUM_IN-1:0][S_MAX-1:0] shadow;
  logic [NUM_IN-1:0]            seen;
  logic [NUM_IN-1:0]            seen_nx;
  logic                         set_full;

  assign seen_nx  = seen | (NUM_IN'(1) << wr_idx);
  assign set_full = &seen_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work   <= '0;
      shadow <= '0;
      seen   <= '0;
    end else if (wr_en) begin
      if (!sync_mode) begin
        work[wr_idx] <= wr_data;
      end else begin
        shadow[wr_idx] <= wr_data;
        if (set_full) begin
          for (int i = 0; i < NUM_IN; i++)
            work[i] <= (IN_AW'(i) == wr_idx) ? wr_data : shadow[i];
          seen <= '0;
        end else begin
          seen <= seen_nx;
        end
      end
    end
  end

  // R8
  async_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !sync_mode |=> work[$past(wr_idx)] == $past(wr_data));
  // R9
  sync_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || (sync_mode && !set_full)) |=> $stable(work));
endmodule

// File: rtl/nm_lane.sv
module nm_lane #(
  parameter int W_MAX  = nm_pkg::DEF_W_MAX,
  parameter int S_MAX  = nm_pkg::DEF_S_MAX,
  parameter int ACC_W  = nm_pkg::DEF_ACC_W,
  localparam int PW    = W_MAX + S_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ACC_W-1:0]  init_val,
  input  logic              step,
  input  logic              ybit,
  input  logic              sign_step,
  input  logic              last_step,
  input  logic [W_MAX-1:0]  wt,
  output logic [ACC_W-1:0]  acc
);
  logic [PW-1:0] prod;
  logic [PW-1:0] term;
  logic [PW-1:0] prod_nx;

  assign term    = ybit ? {{(PW-W_MAX){wt[W_MAX-1]}}, wt} : '0;
  // Sign bit carries negative weight; other bits double then add
  assign prod_nx = sign_step ? (PW'(0) - term) : ((prod << 1) + term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0;
      acc  <= '0;
    end else if (init) begin
      prod <= '0;
      acc  <= init_val;
    end else if (step) begin
      if (last_step) begin
        prod <= '0;
        acc  <= acc + {{(ACC_W-PW){prod_nx[PW-1]}}, prod_nx};
      end else begin
        prod <= prod_nx;
      end
    end
  end

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !init |=> $stable(acc));
endmodule

// File: rtl/nm_ser.sv
module nm_ser #(
  parameter int NUM_OUT = nm_pkg::DEF_LANES,
  parameter int ACC_W   = nm_pkg::DEF_ACC_W,
  localparam int OUT_AW = $clog2(NUM_OUT),
  localparam int BW     = $clog2(ACC_W)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           go,
  input  logic [NUM_OUT-1:0][ACC_W-1:0]  acc_v,
  input  logic                           so_ready,
  output logic                           so_valid,
  output logic                           so_data,
  output logic                           so_last,
  output logic                           done
);
  logic              active;
  logic [OUT_AW-1:0] lane;
  logic [BW-1:0]     pos;
  logic              fire;
  logic              pos_end;
  logic              lane_end;

  assign pos_end  = (pos == BW'(ACC_W-1));
  assign lane_end = (lane == OUT_AW'(NUM_OUT-1));
  assign fire     = active && so_ready;
  assign so_valid = active;
  assign so_data  = active && acc_v[lane][pos];
  assign so_last  = active && pos_end;
  assign done     = fire && pos_end && lane_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lane   <= '0;
      pos    <= '0;
    end else if (go) begin
      active <= 1'b1;
      lane   <= '0;
      pos    <= '0;
    end else if (fire) begin
      if (pos_end) begin
        pos <= '0;
        if (lane_end) active <= 1'b0;
        else          lane   <= lane + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  // R6
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    so_valid && !so_ready |=> so_valid && $stable(so_data) && $stable(so_last));
endmodule

// File: rtl/nm_mac_array.sv
module nm_mac_array #(
  parameter int NUM_IN  = nm_pkg::DEF_INPUTS,
  parameter int NUM_OUT = nm_pkg::DEF_LANES,
  parameter int W_MAX   = nm_pkg::DEF_W_MAX,
  parameter int S_MAX   = nm_pkg::DEF_S_MAX,
  parameter int ACC_W   = nm_pkg::DEF_ACC_W,
  localparam int IN_AW  = $clog2(NUM_IN),
  localparam int OUT_AW = $clog2(NUM_OUT),
  localparam int SB_W   = $clog2(S_MAX)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  output logic                       busy,
  input  logic                       wide_w,
  input  logic [SB_W-1:0]            state_msb,
  input  logic                       psum_en,
  input  logic [NUM_OUT*ACC_W-1:0]   psum_in,
  input  logic                       sync_mode,
  input  logic                       w_we,
  input  logic [IN_AW-1:0]           w_in_sel,
  input  logic [OUT_AW-1:0]          w_out_sel,
  input  logic [W_MAX-1:0]           w_data,
  input  logic                       wb_valid,
  output logic                       wb_ready,
  input  logic [IN_AW-1:0]           wb_idx,
  input  logic [S_MAX-1:0]           wb_data,
  output logic                       so_valid,
  input  logic                       so_ready,
  output logic                       so_data,
  output logic                       so_last
);
  import nm_pkg::*;

  nm_state_e                    st;
  logic [IN_AW-1:0]             in_j;
  logic [SB_W-1:0]              bit_i;
  logic [SB_W-1:0]              msb_q;
  logic                         wide_q;
  logic                         start_ok;
  logic                         mul_step;
  logic                         sign_step;
  logic                         last_step;
  logic                         in_end;
  logic                         mul_done;
  logic                         row_load;
  logic [IN_AW-1:0]             row_sel;
  logic                         ybit;
  logic                         ser_done;
  logic [NUM_IN-1:0][S_MAX-1:0] work;
  logic [NUM_OUT-1:0][W_MAX-1:0] wt_eff;
  logic [NUM_OUT-1:0][ACC_W-1:0] acc_v;
  logic [15:0]                  mul_cnt;

  assign start_ok  = start && (st == ST_IDLE);
  assign mul_step  = (st == ST_MUL);
  assign sign_step = (bit_i == msb_q);
  assign last_step = (bit_i == '0);
  assign in_end    = (in_j == IN_AW'(NUM_IN-1));
  assign mul_done  = mul_step && last_step && in_end;
  assign row_load  = start_ok || (mul_step && last_step && !in_end);
  assign row_sel   = start_ok ? '0 : IN_AW'(in_j + 1'b1);
  assign ybit      = work[in_j][bit_i];
  assign busy      = (st != ST_IDLE);
  assign wb_ready  = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      in_j   <= '0;
      bit_i  <= '0;
      msb_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_MUL;
          in_j   <= '0;
          bit_i  <= state_msb;
          msb_q  <= state_msb;
          wide_q <= wide_w;
        end
        ST_MUL: begin
          if (last_step) begin
            bit_i <= msb_q;
            if (in_end) st <= ST_OUT;
            else        in_j <= in_j + 1'b1;
          end else begin
            bit_i <= bit_i - 1'b1;
          end
        end
        ST_OUT: if (ser_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  nm_wstore #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .W_MAX(W_MAX)) u_wstore (
    .clk(clk), .rst_n(rst_n),
    .we(w_we), .we_row(w_in_sel), .we_col(w_out_sel), .we_data(w_data),
    .row_load(row_load), .row_sel(row_sel), .wide(wide_q),
    .wt_eff(wt_eff)
  );

  nm_sbank #(.NUM_IN(NUM_IN), .S_MAX(S_MAX)) u_sbank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wb_valid && wb_ready), .wr_idx(wb_idx), .wr_data(wb_data),
    .sync_mode(sync_mode), .work(work)
  );

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
    nm_lane #(.W_MAX(W_MAX), .S_MAX(S_MAX), .ACC_W(ACC_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .init(start_ok),
      .init_val(psum_en ? psum_in[k*ACC_W +: ACC_W] : '0),
      .step(mul_step), .ybit(ybit),
      .sign_step(sign_step), .last_step(last_step),
      .wt(wt_eff[k]), .acc(acc_v[k])
    );
  end

  nm_ser #(.NUM_OUT(NUM_OUT), .ACC_W(ACC_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .go(mul_done), .acc_v(acc_v), .so_ready(so_ready),
    .so_valid(so_valid), .so_data(so_data), .so_last(so_last),
    .done(ser_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mul_cnt <= '0;
    else if (mul_step) mul_cnt <= mul_cnt + 16'd1;
    else               mul_cnt <= '0;
  end

  // R5
  mul_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_done |-> (mul_cnt + 16'd1) == 16'(NUM_IN * (32'(msb_q) + 1)));
  // R10
  restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_OUT |=> st != ST_MUL);
endmodule

// File: tb/nm_mac_array_test.sv
module nm_mac_array_test;
  localparam int NI = 16, NO = 16, AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wide_w = 0, psum_en = 0, sync_mode = 0;
  logic [2:0] state_msb = 0;
  logic [NO*AW-1:0] psum_in = '0;
  logic w_we = 0;
  logic [3:0] w_in_sel = 0, w_out_sel = 0, wb_idx = 0;
  logic [15:0] w_data = 0;
  logic wb_valid = 0;
  logic [7:0] wb_data = 0;
  logic so_ready = 0;
  logic busy, wb_ready, so_valid, so_data, so_last;

  int checks = 0, fails = 0;
  logic [15:0] wm [NI][NO];
  logic [7:0]  work_m [NI];
  logic [7:0]  shad_m [NI];
  logic [NI-1:0] seen_m = '0;

  always #10 clk = ~clk;

  nm_mac_array uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .wide_w(wide_w), .state_msb(state_msb), .psum_en(psum_en), .psum_in(psum_in),
    .sync_mode(sync_mode), .w_we(w_we), .w_in_sel(w_in_sel), .w_out_sel(w_out_sel),
    .w_data(w_data), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx),
    .wb_data(wb_data), .so_valid(so_valid), .so_ready(so_ready),
    .so_data(so_data), .so_last(so_last)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] exp_sum(int k, bit wide, int nb, bit pe, logic [31:0] ps);
    longint s = pe ? longint'($signed(ps)) : 0;
    for (int j = 0; j < NI; j++) begin
      longint wv = wide ? longint'($signed(wm[j][k])) : longint'($signed(wm[j][k][7:0]));
      longint yv = longint'(work_m[j]) & ((64'd1 << nb) - 1);
      if (yv >= (64'sd1 << (nb - 1))) yv -= (64'sd1 << nb);
      s += wv * yv;
    end
    return s[31:0];
  endfunction

  task automatic put_w(int j, int k, logic [15:0] d);
    @(negedge clk);
    w_we = 1; w_in_sel = 4'(j); w_out_sel = 4'(k); w_data = d;
    wm[j][k] = d;
    @(negedge clk);
    w_we = 0;
  endtask

  task automatic put_state(int idx, logic [7:0] d);
    @(negedge clk);
    wb_valid = 1; wb_idx = 4'(idx); wb_data = d;
    while (!wb_ready) @(negedge clk);
    @(negedge clk);
    wb_valid = 0;
    if (!sync_mode) work_m[idx] = d;
    else begin
      shad_m[idx] = d;
      seen_m[idx] = 1'b1;
      if (&seen_m) begin
        for (int i = 0; i < NI; i++) work_m[i] = shad_m[i];
        seen_m = '0;
      end
    end
  endtask

  task automatic run(bit wide, int nb, bit pe, bit poke, string req);
    logic [31:0] expv [NO];
    logic [31:0] got [NO];
    int beat = 0, frame_err = 0, hold_err = 0;
    bit pend = 0;
    logic pend_d = 0, pend_l = 0;
    @(negedge clk);
    wide_w = wide; state_msb = 3'(nb - 1); psum_en = pe;
    for (int k = 0; k < NO; k++) psum_in[k*AW +: AW] = $urandom;
    for (int k = 0; k < NO; k++) expv[k] = exp_sum(k, wide, nb, pe, psum_in[k*AW +: AW]);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R5", "busy after start", busy, 1);
    chk(wb_ready === 1'b0, "R7", "wb_ready while busy", wb_ready, 0);
    repeat (NI * nb - 1) @(negedge clk);
    chk(so_valid === 1'b0, "R5", "so_valid one edge early", so_valid, 0);
    @(negedge clk);
    chk(so_valid === 1'b1, "R5", "so_valid on time", so_valid, 1);
    while (beat < NO * AW) begin
      so_ready = ($urandom % 4) != 0;
      start = poke && (beat == 40);
      #1;
      if (pend && !(so_valid && so_data == pend_d && so_last == pend_l)) hold_err++;
      pend = 0;
      if (so_valid && so_ready) begin
        got[beat / AW][beat % AW] = so_data;
        if (so_last != ((beat % AW) == AW - 1)) frame_err++;
        beat++;
      end else if (so_valid) begin
        pend = 1; pend_d = so_data; pend_l = so_last;
      end
      @(negedge clk);
    end
    start = 0; so_ready = 0;
    chk(frame_err == 0, "R6", "so_last framing errors", frame_err, 0);
    chk(hold_err == 0, "R6", "held bit changed", hold_err, 0);
    for (int k = 0; k < NO; k++)
      chk(got[k] == expv[k], req, $sformatf("lane %0d sum", k),
          longint'($signed(got[k])), longint'($signed(expv[k])));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && so_valid === 1'b0, poke ? "R10" : "R1", "idle after pass",
        {busy, so_valid}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < NI; j++) begin
      work_m[j] = 0; shad_m[j] = 0;
      for (int k = 0; k < NO; k++) wm[j][k] = 0;
    end
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R5", "reset busy", busy, 0);
    chk(so_valid === 1'b0, "R6", "reset so_valid", so_valid, 0);
    chk(wb_ready === 1'b1, "R7", "reset wb_ready", wb_ready, 1);
    rst_n = 1;

    for (int j = 0; j < NI; j++)
      for (int k = 0; k < NO; k++) put_w(j, k, 16'($urandom));
    for (int j = 0; j < NI; j++) put_state(j, 8'($urandom));

    run(1, 8, 0, 0, "R1");
    run(1, 8, 1, 0, "R2");
    run(0, 8, 0, 0, "R3");
    for (int nb = 1; nb < 8; nb++) run(1'($urandom), nb, 1'($urandom), 0, "R4");

    // R8: direct write-back is visible to the next pass
    for (int j = 0; j < 4; j++) put_state(j, 8'($urandom));
    run(1, 8, 0, 0, "R8");

    // Signed extremes: most negative weight and state
    for (int j = 0; j < NI; j++)
      for (int k = 0; k < NO; k++) put_w(j, k, 16'h8000);
    for (int j = 0; j < NI; j++) put_state(j, 8'h80);
    run(1, 8, 0, 0, "R1");
    run(0, 8, 0, 0, "R3");
    for (int j = 0; j < NI; j++) put_state(j, 8'hFF);
    run(1, 1, 0, 0, "R4");

    for (int j = 0; j < NI; j++)
      for (int k = 0; k < NO; k++) put_w(j, k, 16'($urandom));
    run(1, 6, 1, 1, "R10");

    // R9: shadowed update only after every index is returned
    sync_mode = 1;
    for (int j = 0; j < NI - 1; j++) put_state(j, 8'($urandom));
    run(1, 8, 0, 0, "R9");
    put_state(NI - 1, 8'($urandom));
    run(1, 8, 0, 0, "R9");

    summary();
  end
endmodule